// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds a wall-clock time and date as seven packed-BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. The year covers one century, 2000 to 2099. A one-cycle enable pulse, normally arriving once a second, advances the seconds. Carries ripple through minutes, hours, the two day counters, the month and the year in the same clock edge. The day of month rolls over at the true length of each month, and February gains its 29th day in leap years.

The hour byte sets its own display format. With bit 6 clear the hour counts 00 to 23. With bit 6 set the hour counts 1 to 12 in BCD in bits 4:0, and bit 5 marks PM. Software loads any field through a single byte-wide write port, selected by a 3-bit field number, and reads all seven bytes and the control byte at once on dedicated outputs. Setting bit 7 of the control byte freezes the count.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (24-hour format), day of week 01, day of month 01, month 01, year 00, and the control byte reads 00.
- R2: Each accepted tick adds one to the seconds in BCD. Seconds 59 wrap to 00 and carry into the minutes, and minutes 59 wrap to 00 and carry into the hour.
- R3: With hour bit 6 clear, the hour counts 00 to 23 in BCD, and 23 wraps to 00 with a carry into the day counters.
- R4: With hour bit 6 set, bits 4:0 count 01 to 12 in BCD and bit 5 is PM. The order is 11 AM, then 12 PM, then 1 PM through 11 PM, then 12 AM (which carries into the day), then 1 AM. Bit 5 toggles only on the step from 11 to 12, and bit 6 is kept.
- R5: The day of month wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R6: In month 02 the day of month wraps after 29 when the BCD year is a multiple of 4 (00 counts), and after 28 otherwise.
- R7: Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R8: The day of week advances by one on each midnight carry and wraps from 07 to 01.
- R9: While control bit 7 is set, ticks change no field. Writes are still accepted. Counting resumes once the bit is cleared.
- R10: A write cycle loads its byte unchanged into the selected field. A tick in that same cycle is dropped, so every other field keeps its value.
- R11: Field numbers on the write port are 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, and 7 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle advance request (1 Hz enable) |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field number for the write |
| wr_data | input | 8 | Byte to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with format and PM flags |
| wday_o | output | 8 | Day of week 1 to 7 |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| ctrl_o | output | 8 | Control byte, bit 7 halts counting |

## Verification
The main stimulus preloads a full date and time, applies one tick, and compares all seven bytes. The starting points are chosen so that each case tells one carry boundary from its neighbours. These include plain BCD digit carries (09 to 10), 24-hour midnight, the 30-day and 31-day month ends, February in leap and common years (including year 00 and a year with an odd tens digit), and the year and century wrap. In 12-hour format the cases separate the PM toggle at 11 to 12 from the plain 12 to 1 step, and separate the true day rollover at 11 PM from the harmless one at 11 AM. Directed cases then show that a halted counter ignores ticks but still takes writes, and that a write landing on a tick wins without disturbing other fields.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] ctrl_o
);

  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q, ctrl_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic step;
  assign step = tick & ~ctrl_q[7] & ~wr_en;

  logic sec_last, min_last, hour_last, mday_last, mon_last;
  assign sec_last = (sec_q == 8'h59);
  assign min_last = (min_q == 8'h59);
  assign mon_last = (mon_q == 8'h12);

  logic hr12, pm;
  logic [4:0] h12;
  logic [7:0] hour_nx;
  assign hr12 = hour_q[6];
  assign pm   = hour_q[5];
  assign h12  = hour_q[4:0];

  always_comb begin
    if (!hr12) begin
      hour_last = (hour_q[5:0] == 6'h23);
      hour_nx   = hour_last ? 8'h00 : {2'b00, bcd_inc({2'b00, hour_q[5:0]})[5:0]};
    end else begin
      hour_last = pm && (h12 == 5'h11);
      if (h12 == 5'h12)      hour_nx = {2'b01, pm, 5'h01};
      else if (h12 == 5'h11) hour_nx = {2'b01, ~pm, 5'h12};
      else                   hour_nx = {2'b01, pm, bcd_inc({3'b000, h12})[4:0]};
    end
  end

  logic leap;
  logic [7:0] mlen;
  assign leap = year_q[4] ? (year_q[3:0] == 4'd2 || year_q[3:0] == 4'd6)
                          : (year_q[3:0] == 4'd0 || year_q[3:0] == 4'd4 ||
                             year_q[3:0] == 4'd8);

  always_comb begin
    case (mon_q)
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end
  assign mday_last = (mday_q == mlen);

  logic c_min, c_hour, c_day, c_mon, c_year;
  assign c_min  = step & sec_last;
  assign c_hour = c_min & min_last;
  assign c_day  = c_hour & hour_last;
  assign c_mon  = c_day & mday_last;
  assign c_year = c_mon & mon_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      wday_q <= 8'h01;
      mday_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      ctrl_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: sec_q  <= wr_data;
        3'd1: min_q  <= wr_data;
        3'd2: hour_q <= wr_data;
        3'd3: wday_q <= wr_data;
        3'd4: mday_q <= wr_data;
        3'd5: mon_q  <= wr_data;
        3'd6: year_q <= wr_data;
        default: ctrl_q <= wr_data;
      endcase
    end else begin
      if (step)   sec_q  <= sec_last ? 8'h00 : bcd_inc(sec_q);
      if (c_min)  min_q  <= min_last ? 8'h00 : bcd_inc(min_q);
      if (c_hour) hour_q <= hour_nx;
      if (c_day) begin
        wday_q <= (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;
        mday_q <= mday_last ? 8'h01 : bcd_inc(mday_q);
      end
      if (c_mon)  mon_q  <= mon_last ? 8'h01 : bcd_inc(mon_q);
      if (c_year) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign wday_o = wday_q;
  assign mday_o = mday_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
  assign ctrl_o = ctrl_q;

  assert_tick_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_o[7] && !wr_en) |=> (sec_o != $past(sec_o)));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[7] && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                               && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));

  assert_write_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> (hour_o == $past(wr_data)));

  assert_write_keeps_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 3'd0) |=> $stable(sec_o));

  assert_mode_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd2) |=> (hour_o[6] == $past(hour_o[6])));

endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, ctrl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .ctrl_o(ctrl_o)
  );

  // rows: {start sec,min,hour,wday,mday,mon,year ; expected after one tick}, then requirement number
  localparam int NV = 23;
  localparam logic [111:0] VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R2
    {56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R2
    {56'h59_09_10_01_01_01_00, 56'h00_10_10_01_01_01_00}, // R2
    {56'h59_59_09_01_01_01_00, 56'h00_00_10_01_01_01_00}, // R3
    {56'h59_59_23_03_15_06_24, 56'h00_00_00_04_16_06_24}, // R3 R8
    {56'h59_59_23_07_30_04_24, 56'h00_00_00_01_01_05_24}, // R5 R8
    {56'h59_59_23_02_30_05_24, 56'h00_00_00_03_31_05_24}, // R5
    {56'h59_59_23_02_31_05_24, 56'h00_00_00_03_01_06_24}, // R5
    {56'h59_59_23_04_30_09_24, 56'h00_00_00_05_01_10_24}, // R5
    {56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24}, // R6
    {56'h59_59_23_01_29_02_24, 56'h00_00_00_02_01_03_24}, // R6
    {56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23}, // R6
    {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00}, // R6
    {56'h59_59_23_01_28_02_12, 56'h00_00_00_02_29_02_12}, // R6
    {56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_01_00}, // R7
    {56'h59_59_23_05_31_12_09, 56'h00_00_00_06_01_01_10}, // R7
    {56'h59_59_51_01_10_03_24, 56'h00_00_72_01_10_03_24}, // R4
    {56'h59_59_72_01_10_03_24, 56'h00_00_61_01_10_03_24}, // R4
    {56'h59_59_71_01_10_03_24, 56'h00_00_52_02_11_03_24}, // R4
    {56'h59_59_52_01_10_03_24, 56'h00_00_41_01_10_03_24}, // R4
    {56'h59_59_49_01_10_03_24, 56'h00_00_50_01_10_03_24}, // R4
    {56'h59_59_69_01_10_03_24, 56'h00_00_70_01_10_03_24}, // R4
    {56'h59_59_19_01_10_03_24, 56'h00_00_20_01_10_03_24}  // R3
  };
  localparam int VREQ [NV] = '{2,2,2,3,3,5,5,5,5,6,6,6,6,6,7,7,4,4,4,4,4,4,3};

  function automatic logic [55:0] snap();
    return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {8'h0, snap()}, {8'h0, 56'h00_00_00_01_01_01_00});
    chk("R1 ctrl", {56'h0, ctrl_o}, 64'h00);

    for (int i = 0; i < NV; i++) begin
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[i][111 - 8*f -: 8]); // R11 field numbers
      pulse();
      chk($sformatf("R%0d row %0d", VREQ[i], i), {8'h0, snap()}, {8'h0, VEC[i][55:0]});
    end

    // R9 halt
    wr(3'd0, 8'h10);
    wr(3'd7, 8'h80);
    chk("R11 ctrl read", {56'h0, ctrl_o}, 64'h80);
    pulse(); pulse(); pulse();
    chk("R9 halted", {56'h0, sec_o}, 64'h10);
    wr(3'd0, 8'h20);
    chk("R9 write while halted", {56'h0, sec_o}, 64'h20);
    pulse();
    chk("R9 still halted", {56'h0, sec_o}, 64'h20);
    wr(3'd7, 8'h00);
    pulse();
    chk("R9 resumed", {56'h0, sec_o}, 64'h21);

    // R10 write beats tick
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h10);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h30; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R10 sec held", {56'h0, sec_o}, 64'h05);
    chk("R10 min loaded", {56'h0, min_o}, 64'h30);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h59; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R10 sec loaded", {56'h0, sec_o}, 64'h59);
    chk("R10 min untouched", {56'h0, min_o}, 64'h30);
    pulse();
    chk("R2 carry after write", {48'h0, sec_o, min_o}, {48'h0, 16'h0031});

    finish_run();
  end
endmodule